// File: doc/BRIEF.md
# Three-Phase Synchronous-Frame Digital PLL

This block tracks the phase angle and frequency of a balanced three-phase voltage. It runs at a fixed sample rate. On each sample strobe it takes three signed phase voltages. Using sine and cosine of its own angle estimate, read from an internal quarter-wave table, it projects them onto a rotating frame. This yields a direct component d and a quadrature component q. The quadrature component serves as the phase error. It passes through a backward-Euler PI filter whose integrator saturates at a limit set on a port. A constant feed-forward frequency is added to the filter output, and the sum is accumulated into the angle.

The angle is an unsigned fraction of a full turn, so it wraps modulo one turn without extra logic. Frequency is expressed in angle LSBs per sample. The arctangent phase detector is replaced by its small-angle form. The error term is q itself, with the reciprocal of the nominal amplitude folded into the two gain ports. Every state update happens on the strobe, and a synchronous reset brings the loop to a known start.

Top module: `srf_dpll`

## Requirements
- R1: While reset is held, the next clock edge sets the angle to 0, d and q to 0, the PI integrator to 0, and the frequency output to the zero-extended feed-forward input.
- R2: On a clock edge without the sample strobe, angle, frequency, d and q keep their values whatever the other inputs do.
- R3: The sine of a 16-bit angle uses only its top 8 bits. Bits 15:14 are the quadrant and bits 13:8 the index i. The magnitude is T[i] in quadrants 0 and 2 and T[64-i] in quadrants 1 and 3. It is negated in quadrants 2 and 3. T[u] = floor(16384*16*u*(128-u) / (81920 - 4*u*(128-u))) for u = 0..64.
- R4: On a strobe, d becomes clamp(floor((va*S(a) + vb*S(a-21845) + vc*S(a+21845)) * 43691 / 2^30), -32768, 32767). Here a is the angle held before that strobe and all angle sums are taken modulo 2^16.
- R5: On a strobe, q is formed like d but with C(x) = S(x+16384) in place of S.
- R6: On a strobe, the integrator becomes clamp(I + floor(ki*q/1024), -ilim, +ilim), where q is the value computed in that same sample.
- R7: On a strobe, the frequency output becomes ff_inc + floor(kp*q/1024) + the updated integrator, as a 32-bit signed value.
- R8: On a strobe, the angle becomes (angle + new frequency) modulo 2^16, so the present sample's frequency already moves the angle.
- R9: Consider a balanced input of amplitude 10000 whose phase starts 5461 LSB ahead and advances 660 LSB per sample, with ff_inc = 655, kp = 100, ki = 4 and ilim = 4096. After 1976 samples, the angle stays within 1200 LSB of the next input phase, and the mean frequency over the next 1024 samples is within 3 of 660.
- R10: The integrator never leaves [-ilim, +ilim]. With kp = 0, a large positive error drives the frequency to exactly ff_inc + ilim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe per sampling period |
| va | input | DW (16) | Phase A voltage, signed |
| vb | input | DW (16) | Phase B voltage, signed |
| vc | input | DW (16) | Phase C voltage, signed |
| ff_inc | input | AW (16) | Feed-forward frequency, angle LSBs per sample |
| kp | input | GW (16) | Proportional gain, scaled by 2^-10 |
| ki | input | GW (16) | Integral gain, scaled by 2^-10 |
| ilim | input | LW (24) | Integrator saturation magnitude |
| angle_o | output | AW (16) | Angle estimate, fraction of a turn |
| freq_o | output | FW (32) | Frequency estimate, signed |
| d_o | output | DW (16) | Direct component, signed |
| q_o | output | DW (16) | Quadrature component, signed |

## Verification
All four results (d, q, frequency and angle) are registered on the strobe edge. Each is therefore due exactly one clock after the cycle in which the strobe is high. The bench raises the strobe at a falling edge, lowers it at the next falling edge and reads the outputs there, one edge after the update. To check hold behaviour, the bench changes inputs over several strobe-free cycles and reads the outputs after each of them. The lock test is the exception: it judges only samples from 1976 onward, when the loop has had time to settle, and it compares each angle with the input phase of the following sample, because the angle update already contains that step.

// File: rtl/srfpll_pkg.sv
`timescale 1ns/1ps
package srfpll_pkg;

  // 2/3 expressed with 16 fraction bits
  localparam longint TWO_THIRDS_Q16 = 43691;

  // Rational sine approximation over a half turn of "half" steps, scaled by amp
  function automatic longint bh_sine(longint u, longint half, longint amp);
    longint r;
    r = half - u;
    return (amp * 16 * u * r) / (5 * half * half - 4 * u * r);
  endfunction

  function automatic longint clampl(longint x, longint lo, longint hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // gain product with arithmetic (floor) right shift
  function automatic longint gain_shift(longint g, longint x, int sh);
    return (g * x) >>> sh;
  endfunction

  // 2/3 frame scaling, removing the table amplitude bits as well
  function automatic longint frame_scale(longint acc, int amp_b);
    return (acc * TWO_THIRDS_Q16) >>> (16 + amp_b);
  endfunction

endpackage

// File: rtl/srf_sine_lut.sv
`timescale 1ns/1ps
module srf_sine_lut #(
  parameter int AW    = 16,
  parameter int QB    = 6,
  parameter int SW    = 16,
  parameter int AMP_B = 14
) (
  input  logic [AW-1:0]        ang,
  output logic signed [SW-1:0] sin_o
);
  localparam int Q  = 1 << QB;
  localparam int SH = AW - QB - 2;

  logic signed [SW-1:0] tab [0:Q];
  logic [QB+1:0]        top_bits;
  logic [QB:0]          sel;
  logic signed [SW-1:0] mag;

  for (genvar gi = 0; gi <= Q; gi++) begin : g_tab
    assign tab[gi] = SW'(srfpll_pkg::bh_sine(longint'(gi), longint'(2 * Q),
                                             longint'(1) << AMP_B));
  end

  assign top_bits = (QB+2)'(ang >> SH);

  always_comb begin
    sel   = top_bits[QB] ? ((QB+1)'(Q) - {1'b0, top_bits[QB-1:0]})
                         : {1'b0, top_bits[QB-1:0]};
    mag   = tab[sel];
    sin_o = top_bits[QB+1] ? -mag : mag;
  end

endmodule

// File: rtl/srf_dq_proj.sv
`timescale 1ns/1ps
module srf_dq_proj #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int QB    = 6,
  parameter int SW    = 16,
  parameter int AMP_B = 14
) (
  input  logic [AW-1:0]        angle,
  input  logic signed [DW-1:0] va,
  input  logic signed [DW-1:0] vb,
  input  logic signed [DW-1:0] vc,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] q_o
);
  localparam logic [AW-1:0] THIRD = AW'((longint'(1) << AW) / 3);
  localparam logic [AW-1:0] QTR   = AW'(longint'(1) << (AW - 2));
  localparam longint        VMAX  = (longint'(1) << (DW - 1)) - 1;

  // taps 0..2: sine row at a, a-third, a+third; taps 3..5: same shifted a quarter turn
  function automatic logic [AW-1:0] tap_ofs(int k);
    logic [AW-1:0] base;
    base = (k >= 3) ? QTR : '0;
    case (k % 3)
      1:       return base - THIRD;
      2:       return base + THIRD;
      default: return base;
    endcase
  endfunction

  logic signed [SW-1:0] tap     [6];
  logic [AW-1:0]        tap_ang [6];

  for (genvar gk = 0; gk < 6; gk++) begin : g_tap
    assign tap_ang[gk] = angle + tap_ofs(gk);
    srf_sine_lut #(.AW(AW), .QB(QB), .SW(SW), .AMP_B(AMP_B)) u_lut (
      .ang  (tap_ang[gk]),
      .sin_o(tap[gk])
    );
  end

  longint acc_d, acc_q;

  always_comb begin
    acc_d = longint'(va) * longint'(tap[0]) + longint'(vb) * longint'(tap[1])
          + longint'(vc) * longint'(tap[2]);
    acc_q = longint'(va) * longint'(tap[3]) + longint'(vb) * longint'(tap[4])
          + longint'(vc) * longint'(tap[5]);
    d_o = DW'(srfpll_pkg::clampl(srfpll_pkg::frame_scale(acc_d, AMP_B), -VMAX - 1, VMAX));
    q_o = DW'(srfpll_pkg::clampl(srfpll_pkg::frame_scale(acc_q, AMP_B), -VMAX - 1, VMAX));
  end

endmodule

// File: rtl/srf_pi.sv
`timescale 1ns/1ps
module srf_pi #(
  parameter int DW = 16,
  parameter int GW = 16,
  parameter int LW = 24,
  parameter int FW = 32,
  parameter int GS = 10,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic signed [DW-1:0] err,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [LW-1:0]        ilim,
  input  logic [AW-1:0]        ff,
  output logic signed [FW-1:0] freq_nx
);
  logic signed [FW-1:0] integ, integ_nx, lim_s;
  longint p_l, i_l;

  assign lim_s = FW'(ilim);

  always_comb begin
    p_l      = srfpll_pkg::gain_shift(longint'(kp), longint'(err), GS);
    i_l      = srfpll_pkg::gain_shift(longint'(ki), longint'(err), GS);
    integ_nx = FW'(srfpll_pkg::clampl(longint'(integ) + i_l,
                                      -longint'(lim_s), longint'(lim_s)));
    freq_nx  = FW'(longint'(ff) + p_l + longint'(integ_nx));
  end

  always_ff @(posedge clk) begin
    if (rst)      integ <= '0;
    else if (stb) integ <= integ_nx;
  end

  // R10
  integ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> (integ <= $past(lim_s) && integ >= -$past(lim_s)));

endmodule

// File: rtl/srf_dpll.sv
`timescale 1ns/1ps
module srf_dpll #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int QB    = 6,
  parameter int SW    = 16,
  parameter int AMP_B = 14,
  parameter int GW    = 16,
  parameter int LW    = 24,
  parameter int FW    = 32,
  parameter int GS    = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] va,
  input  logic signed [DW-1:0] vb,
  input  logic signed [DW-1:0] vc,
  input  logic [AW-1:0]        ff_inc,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [LW-1:0]        ilim,
  output logic [AW-1:0]        angle_o,
  output logic signed [FW-1:0] freq_o,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] q_o
);
  logic signed [DW-1:0] d_cur, q_cur;
  logic signed [FW-1:0] freq_nx;

  srf_dq_proj #(.DW(DW), .AW(AW), .QB(QB), .SW(SW), .AMP_B(AMP_B)) u_proj (
    .angle(angle_o),
    .va   (va),
    .vb   (vb),
    .vc   (vc),
    .d_o  (d_cur),
    .q_o  (q_cur)
  );

  srf_pi #(.DW(DW), .GW(GW), .LW(LW), .FW(FW), .GS(GS), .AW(AW)) u_pi (
    .clk    (clk),
    .rst    (rst),
    .stb    (smp_stb),
    .err    (q_cur),
    .kp     (kp),
    .ki     (ki),
    .ilim   (ilim),
    .ff     (ff_inc),
    .freq_nx(freq_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      angle_o <= '0;
      freq_o  <= FW'(ff_inc);
      d_o     <= '0;
      q_o     <= '0;
    end else if (smp_stb) begin
      angle_o <= angle_o + freq_nx[AW-1:0];
      freq_o  <= freq_nx;
      d_o     <= d_cur;
      q_o     <= q_cur;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (angle_o == '0 && d_o == '0 && q_o == '0 && freq_o == FW'($past(ff_inc))));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(angle_o) && $stable(freq_o) && $stable(d_o) && $stable(q_o)));

  // R8
  angle_step_chk: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> (angle_o == $past(angle_o) + freq_o[AW-1:0]));

endmodule

// File: tb/test_srf_dpll.sv
`timescale 1ns/1ps
module test_srf_dpll;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic signed [15:0] va = '0, vb = '0, vc = '0;
  logic [15:0] ff = 16'd655, kp = '0, ki = '0;
  logic [23:0] ilim = 24'd5000;
  wire  [15:0] angle;
  wire  signed [31:0] freq;
  wire  signed [15:0] d, q;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  longint tb_tab [0:64];
  longint m_ang, m_int, m_freq, m_d, m_q;

  localparam int NV = 10;
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, -8660, 8660}, '{10000, 0, 0}, '{0, 10000, 0}, '{0, 0, 10000},
    '{-32768, -32768, -32768}, '{32767, -32768, 32767}, '{5000, -2500, -2500},
    '{-7000, 3500, 3500}, '{1234, -4321, 3087}, '{32767, 32767, -32768}};

  always #4 clk = ~clk;

  srf_dpll i_srf_dpll (
    .clk(clk), .rst(rst), .smp_stb(stb), .va(va), .vb(vb), .vc(vc),
    .ff_inc(ff), .kp(kp), .ki(ki), .ilim(ilim),
    .angle_o(angle), .freq_o(freq), .d_o(d), .q_o(q));

  function automatic longint clampr(longint x, longint lo, longint hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  // sine per the quadrant/index rule of R3
  function automatic longint bsin(longint a);
    longint h, qd, ix, m;
    h  = (a & 65535) >> 8;
    qd = h >> 6;
    ix = h & 63;
    m  = (qd % 2 == 1) ? tb_tab[64 - ix] : tb_tab[ix];
    return (qd >= 2) ? -m : m;
  endfunction

  task automatic model_step(int a, int b, int c);
    longint v [3];
    longint ad, aq, off;
    v[0] = a; v[1] = b; v[2] = c;
    ad = 0; aq = 0;
    for (int k = 0; k < 3; k++) begin
      off = (k == 0) ? 0 : ((k == 1) ? -21845 : 21845);
      ad += v[k] * bsin(m_ang + off);
      aq += v[k] * bsin(m_ang + off + 16384);
    end
    m_d    = clampr((ad * 43691) >>> 30, -32768, 32767);
    m_q    = clampr((aq * 43691) >>> 30, -32768, 32767);
    m_int  = clampr(m_int + ((longint'(ki) * m_q) >>> 10), -longint'(ilim), longint'(ilim));
    m_freq = longint'(ff) + ((longint'(kp) * m_q) >>> 10) + m_int;
    m_ang  = (m_ang + m_freq) & 65535;
  endtask

  task automatic strobe(int a, int b, int c);
    @(negedge clk);
    va = a[15:0]; vb = b[15:0]; vc = c[15:0];
    stb = 1'b1;
    model_step(a, b, c);
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_ang = 0; m_int = 0; m_freq = longint'(ff);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint sf, mx, dd, pn;
    real rad;
    int ph, a0, b0, c0;
    for (int u = 0; u <= 64; u++)
      tb_tab[u] = (longint'(16384) * 16 * u * (128 - u)) / (81920 - 4 * u * (128 - u));

    // R1: reset state
    kp = 16'd100; ki = 16'd20; ilim = 24'd5000; ff = 16'd655;
    do_reset();
    chk("R1 angle", angle, 0);
    chk("R1 freq", freq, 655);
    chk("R1 d", d, 0);
    chk("R1 q", q, 0);

    // R2: inputs move, no strobe
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      va = 16'(1000 * (i + 1)); vb = -16'(700 * i); vc = 16'(3 * i);
      @(negedge clk);
      chk("R2 hold", longint'(angle) + longint'(freq) + longint'(d) + longint'(q), 655);
    end

    // vector table: R3 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][0], VEC[i][1], VEC[i][2]);
      chk("R3 R4 d", d, m_d);
      chk("R5 q", q, m_q);
      chk("R7 freq", freq, m_freq);
      chk("R8 angle", angle, m_ang);
    end

    // R6: integral path alone
    kp = 16'd0; ki = 16'd3; ilim = 24'd100000; ff = 16'd400;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      strobe(6000, -1000, -5000);
      chk("R6 integrator via freq", freq, m_freq);
    end

    // R10: integrator clamps at +ilim
    kp = 16'd0; ki = 16'd1000; ilim = 24'd300; ff = 16'd655;
    do_reset();
    strobe(10000, 0, 0);
    chk("R10 clamp", freq, 655 + 300);
    chk("R10 clamp model", freq, m_freq);

    // R8: wrap of the angle
    kp = 16'd0; ki = 16'd0; ff = 16'd65000;
    do_reset();
    strobe(0, 0, 0);
    chk("R8 first step", angle, 65000);
    strobe(0, 0, 0);
    chk("R8 wrap", angle, (2 * 65000) % 65536);

    // R9: closed-loop lock
    kp = 16'd100; ki = 16'd4; ilim = 24'd4096; ff = 16'd655;
    do_reset();
    sf = 0; mx = 0;
    for (int k = 0; k < 3000; k++) begin
      ph  = (5461 + k * 660) % 65536;
      rad = 6.283185307179586 * ph / 65536.0;
      a0  = $rtoi(10000.0 * $sin(rad) + 100000.5) - 100000;
      b0  = $rtoi(10000.0 * $sin(rad - 2.0943951023931953) + 100000.5) - 100000;
      c0  = $rtoi(10000.0 * $sin(rad + 2.0943951023931953) + 100000.5) - 100000;
      strobe(a0, b0, c0);
      if (k >= 1976) begin
        pn = (ph + 660) % 65536;
        dd = ((longint'(angle) - pn + 32768 + 65536) % 65536) - 32768;
        if (dd < 0) dd = -dd;
        if (dd > mx) mx = dd;
        sf += longint'(freq);
      end
    end
    chk("R9 angle error within 1200", (mx <= 1200) ? 1 : 0, 1);
    chk("R9 mean frequency near 660",
        ((sf >= 1024 * 657) && (sf <= 1024 * 663)) ? 1 : 0, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule